// File: doc/BRIEF.md
# Receive FIFO Threshold Flow Controller

This block watches the fill level of a 64-entry receive FIFO and decides when the far-end transmitter should stop and when it may start again. Two register fields set the stop and restart levels, each in units of four entries. Because the restart level sits below the stop level, the block has hysteresis. Between a stop and the following restart it holds a sticky paused state.

The block has two flow-control modes. In the in-band mode it asks the local transmitter to insert a programmed pause character or resume character. It holds that request until the transmitter accepts it. In the out-of-band mode it drives an active-low request-to-send line, which goes high while the block is paused. A separate trigger field sets a receive interrupt level, also in units of four. The FIFO storage, serial framing and baud generation are outside this block.

Top module: `rx_flow_ctrl`

## Requirements
- R1: The stop level is `thr_cfg[3:0]*4` and the restart level is `thr_cfg[7:4]*4`, both compared against `rx_level`.
- R2: When `sw_flow_en` is 1, the block is not paused and `rx_level` is at or above the stop level, the block becomes paused. On the next clock edge `ins_req` goes to 1 and `ins_char` equals `pause_char`.
- R3: When the block is paused and `rx_level` is at or below the restart level, it leaves the paused state. If `sw_flow_en` is 1, `ins_req` goes to 1 on the next clock edge and `ins_char` equals `resume_char`.
- R4: Only one pause character is requested for each upward crossing and only one resume character for each downward crossing. Nothing is requested again while the level stays beyond a threshold.
- R5: `ins_req` stays at 1 until a cycle in which `ins_ack` is 1, and then drops on the next edge. `ins_char` keeps its last value. A newer pause or resume event replaces `ins_char` and keeps `ins_req` at 1.
- R6: When `hw_flow_en` is 1, `rts_n` goes to 1 one edge after the block enters the paused state and back to 0 one edge after it leaves it. When `hw_flow_en` is 0, `rts_n` is 0. No character is requested unless `sw_flow_en` is 1.
- R7: If the restart level is not below the stop level, the configuration is invalid and the block never enters the paused state.
- R8: `rx_trig_irq` is 1 one edge after `rx_level` is nonzero and at or above `trig_cfg*4`. Otherwise it is 0.
- R9: Reset clears the paused state and sets `ins_req`, `ins_char`, `rts_n` and `rx_trig_irq` to 0.
- R10: With both mode enables at 0, the block does not enter the paused state, whatever the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | 7 | Current receive FIFO fill level, 0 to 64 |
| thr_cfg | input | 8 | Stop level field [3:0] and restart level field [7:4] |
| trig_cfg | input | 4 | Receive interrupt trigger field |
| sw_flow_en | input | 1 | Enables in-band flow control (character insertion) |
| hw_flow_en | input | 1 | Enables out-of-band flow control (request-to-send line) |
| pause_char | input | 8 | Programmed pause character |
| resume_char | input | 8 | Programmed resume character |
| ins_ack | input | 1 | Local transmitter accepts the pending inserted character |
| ins_req | output | 1 | Request to insert `ins_char` at the next character boundary |
| ins_char | output | 8 | Character to insert |
| rts_n | output | 1 | Active-low request-to-send; 1 asks the far end to stop |
| rx_trig_irq | output | 1 | Receive trigger interrupt flag |

## Verification
A wrong paused state is visible at the ports one edge later. It shows as a pause or resume character that is requested when it should not be, is missing, or is requested twice, or as `rts_n` held at the wrong level. The bench therefore checks every output one edge after each change of level, mode or configuration. It includes steps where the level stays above or below a threshold, to show that no request repeats. A request that is lost or cleared too early shows at once as `ins_req` dropping before the acknowledge. A bad compare at a threshold shows at the exact boundary levels (59 against 60, and 32).

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {
    EVT_NONE   = 2'd0,
    EVT_PAUSE  = 2'd1,
    EVT_RESUME = 2'd2
  } flow_evt_e;
endpackage

// File: rtl/rfc_thresh.sv
// Scales packed register fields into FIFO levels (field << SHIFT).
module rfc_thresh #(
  parameter int FIELD_W = 4,
  parameter int LEVEL_W = 7,
  parameter int SHIFT   = 2,
  parameter int NF      = 3
) (
  input  logic [NF*FIELD_W-1:0] fields,
  output logic [NF*LEVEL_W-1:0] levels
);
  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_scale
      assign levels[i*LEVEL_W +: LEVEL_W] =
        LEVEL_W'(fields[i*FIELD_W +: FIELD_W]) << SHIFT;
    end
  endgenerate
endmodule

// File: rtl/rfc_pause_ctrl.sv
// Sticky paused state with hysteresis between stop and restart levels.
module rfc_pause_ctrl
  import rfc_pkg::*;
#(
  parameter int LEVEL_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVEL_W-1:0] level,
  input  logic [LEVEL_W-1:0] stop_lvl,
  input  logic [LEVEL_W-1:0] go_lvl,
  input  logic               cfg_ok,
  input  logic               enable,
  output logic               paused,
  output logic               paused_nxt,
  output flow_evt_e          evt
);
  always_comb begin
    evt = EVT_NONE;
    if (!paused && enable && cfg_ok && (level >= stop_lvl))
      evt = EVT_PAUSE;
    else if (paused && (level <= go_lvl))
      evt = EVT_RESUME;
  end

  always_comb begin
    case (evt)
      EVT_PAUSE:  paused_nxt = 1'b1;
      EVT_RESUME: paused_nxt = 1'b0;
      default:    paused_nxt = paused;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) paused <= 1'b0;
    else     paused <= paused_nxt;
  end
endmodule

// File: rtl/rfc_signal_out.sv
// Turns pause/resume events into an insert request or an RTS level.
module rfc_signal_out
  import rfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  flow_evt_e         evt,
  input  logic              paused_nxt,
  input  logic              sw_en,
  input  logic              hw_en,
  input  logic [CHAR_W-1:0] pause_code,
  input  logic [CHAR_W-1:0] resume_code,
  input  logic              ack,
  output logic              req,
  output logic [CHAR_W-1:0] code,
  output logic              rts_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      code  <= '0;
      rts_n <= 1'b0;
    end else begin
      rts_n <= hw_en & paused_nxt;
      if (sw_en && (evt == EVT_PAUSE)) begin
        req  <= 1'b1;
        code <= pause_code;
      end else if (sw_en && (evt == EVT_RESUME)) begin
        req  <= 1'b1;
        code <= resume_code;
      end else if (ack) begin
        req  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
  import rfc_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int FIELD_W = 4,
  parameter int SHIFT   = 2,
  parameter int CHAR_W  = 8,
  localparam int LEVEL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic [2*FIELD_W-1:0] thr_cfg,
  input  logic [FIELD_W-1:0] trig_cfg,
  input  logic               sw_flow_en,
  input  logic               hw_flow_en,
  input  logic [CHAR_W-1:0]  pause_char,
  input  logic [CHAR_W-1:0]  resume_char,
  input  logic               ins_ack,
  output logic               ins_req,
  output logic [CHAR_W-1:0]  ins_char,
  output logic               rts_n,
  output logic               rx_trig_irq
);
  localparam int NF = 3;

  logic [NF*LEVEL_W-1:0] lvls;
  logic [LEVEL_W-1:0]    stop_lvl, go_lvl, trig_lvl;
  logic                  cfg_ok, paused, paused_nxt;
  flow_evt_e             evt;

  // field 0: stop, field 1: restart, field 2: interrupt trigger
  rfc_thresh #(
    .FIELD_W(FIELD_W), .LEVEL_W(LEVEL_W), .SHIFT(SHIFT), .NF(NF)
  ) u_thresh (
    .fields({trig_cfg, thr_cfg[2*FIELD_W-1:FIELD_W], thr_cfg[FIELD_W-1:0]}),
    .levels(lvls)
  );

  assign stop_lvl = lvls[0*LEVEL_W +: LEVEL_W];
  assign go_lvl   = lvls[1*LEVEL_W +: LEVEL_W];
  assign trig_lvl = lvls[2*LEVEL_W +: LEVEL_W];
  assign cfg_ok   = go_lvl < stop_lvl;

  rfc_pause_ctrl #(.LEVEL_W(LEVEL_W)) u_pause (
    .clk(clk), .rst(rst), .level(rx_level),
    .stop_lvl(stop_lvl), .go_lvl(go_lvl), .cfg_ok(cfg_ok),
    .enable(sw_flow_en | hw_flow_en),
    .paused(paused), .paused_nxt(paused_nxt), .evt(evt)
  );

  rfc_signal_out #(.CHAR_W(CHAR_W)) u_out (
    .clk(clk), .rst(rst), .evt(evt), .paused_nxt(paused_nxt),
    .sw_en(sw_flow_en), .hw_en(hw_flow_en),
    .pause_code(pause_char), .resume_code(resume_char),
    .ack(ins_ack), .req(ins_req), .code(ins_char), .rts_n(rts_n)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_trig_irq <= 1'b0;
    else     rx_trig_irq <= (rx_level != '0) && (rx_level >= trig_lvl);
  end
endmodule

// File: rtl/rx_flow_ctrl_chk.sv
module rx_flow_ctrl_chk #(
  parameter int LEVEL_W = 7,
  parameter int FIELD_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [LEVEL_W-1:0] rx_level,
  input logic [2*FIELD_W-1:0] thr_cfg,
  input logic               sw_flow_en,
  input logic               hw_flow_en,
  input logic               ins_ack,
  input logic               ins_req,
  input logic               rts_n,
  input logic               rx_trig_irq
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    ins_req && !ins_ack |=> ins_req); // R5
  AST_NO_INSERT_WITHOUT_SW: assert property (@(posedge clk) disable iff (rst)
    !sw_flow_en && !ins_req |=> !ins_req); // R6
  AST_RTS_LOW_WITHOUT_HW: assert property (@(posedge clk) disable iff (rst)
    !hw_flow_en |=> !rts_n); // R6
  AST_INVALID_NO_PAUSE: assert property (@(posedge clk) disable iff (rst)
    (thr_cfg[2*FIELD_W-1:FIELD_W] >= thr_cfg[FIELD_W-1:0]) && !rts_n |=> !rts_n); // R7
  AST_IRQ_QUIET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_level == '0 |=> !rx_trig_irq); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!ins_req && !rts_n && !rx_trig_irq)); // R9
endmodule

bind rx_flow_ctrl rx_flow_ctrl_chk #(.LEVEL_W(LEVEL_W), .FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst(rst), .rx_level(rx_level), .thr_cfg(thr_cfg),
  .sw_flow_en(sw_flow_en), .hw_flow_en(hw_flow_en), .ins_ack(ins_ack),
  .ins_req(ins_req), .rts_n(rts_n), .rx_trig_irq(rx_trig_irq)
);

// File: tb/rx_flow_ctrl_bench.sv
`timescale 1ns/1ps
module rx_flow_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] rx_level = '0;
  logic [7:0] thr_cfg = 8'h8F;
  logic [3:0] trig_cfg = 4'hD;
  logic       sw_flow_en = 1'b0, hw_flow_en = 1'b0;
  logic [7:0] pause_char = 8'h0F, resume_char = 8'h0D;
  logic       ins_ack = 1'b0;
  logic       ins_req, rts_n, rx_trig_irq;
  logic [7:0] ins_char;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  rx_flow_ctrl u_rx_flow_ctrl (
    .clk(clk), .rst(rst), .rx_level(rx_level), .thr_cfg(thr_cfg),
    .trig_cfg(trig_cfg), .sw_flow_en(sw_flow_en), .hw_flow_en(hw_flow_en),
    .pause_char(pause_char), .resume_char(resume_char), .ins_ack(ins_ack),
    .ins_req(ins_req), .ins_char(ins_char), .rts_n(rts_n),
    .rx_trig_irq(rx_trig_irq)
  );

  // row: sw[28] hw[27] thr[26:19] lvl[18:12] ack[11] | req[10] char[9:2] rts[1] irq[0]
  // stop = 0xF*4 = 60, restart = 0x8*4 = 32 (R1), trigger 0xD*4 = 52
  localparam int NROW = 21;
  localparam logic [28:0] TBL [0:NROW-1] = '{
    {1'b1,1'b0,8'h8F,7'd10,1'b0, 1'b0,8'h00,1'b0,1'b0},
    {1'b1,1'b0,8'h8F,7'd52,1'b0, 1'b0,8'h00,1'b0,1'b1},
    {1'b1,1'b0,8'h8F,7'd59,1'b0, 1'b0,8'h00,1'b0,1'b1},
    {1'b1,1'b0,8'h8F,7'd60,1'b0, 1'b1,8'h0F,1'b0,1'b1}, // R2
    {1'b1,1'b0,8'h8F,7'd61,1'b0, 1'b1,8'h0F,1'b0,1'b1}, // R5 hold
    {1'b1,1'b0,8'h8F,7'd61,1'b1, 1'b0,8'h0F,1'b0,1'b1}, // R5 ack
    {1'b1,1'b0,8'h8F,7'd62,1'b0, 1'b0,8'h0F,1'b0,1'b1}, // R4
    {1'b1,1'b0,8'h8F,7'd40,1'b0, 1'b0,8'h0F,1'b0,1'b0},
    {1'b1,1'b0,8'h8F,7'd32,1'b0, 1'b1,8'h0D,1'b0,1'b0}, // R3
    {1'b1,1'b0,8'h8F,7'd32,1'b1, 1'b0,8'h0D,1'b0,1'b0},
    {1'b1,1'b0,8'h8F,7'd20,1'b0, 1'b0,8'h0D,1'b0,1'b0}, // R4
    {1'b0,1'b1,8'h8F,7'd60,1'b0, 1'b0,8'h0D,1'b1,1'b1}, // R6
    {1'b0,1'b1,8'h8F,7'd45,1'b0, 1'b0,8'h0D,1'b1,1'b0},
    {1'b0,1'b1,8'h8F,7'd32,1'b0, 1'b0,8'h0D,1'b0,1'b0},
    {1'b0,1'b1,8'h8F,7'd64,1'b0, 1'b0,8'h0D,1'b1,1'b1},
    {1'b0,1'b1,8'h8F,7'd0 ,1'b0, 1'b0,8'h0D,1'b0,1'b0},
    {1'b1,1'b1,8'h88,7'd64,1'b0, 1'b0,8'h0D,1'b0,1'b1}, // R7
    {1'b0,1'b0,8'h8F,7'd64,1'b0, 1'b0,8'h0D,1'b0,1'b1}, // R10
    {1'b1,1'b0,8'h8F,7'd64,1'b0, 1'b1,8'h0F,1'b0,1'b1},
    {1'b1,1'b0,8'h8F,7'd30,1'b0, 1'b1,8'h0D,1'b0,1'b0}, // R5 overwrite
    {1'b1,1'b0,8'h8F,7'd30,1'b1, 1'b0,8'h0D,1'b0,1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 ins_req", ins_req, 0);
    chk("R9 ins_char", ins_char, 0);
    chk("R9 rts_n", rts_n, 0);
    chk("R9 irq", rx_trig_irq, 0);
    rst = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      sw_flow_en = TBL[i][28];
      hw_flow_en = TBL[i][27];
      thr_cfg    = TBL[i][26:19];
      rx_level   = TBL[i][18:12];
      ins_ack    = TBL[i][11];
      step();
      chk($sformatf("R2 R3 R4 R5 row%0d ins_req", i), ins_req, TBL[i][10]);
      chk($sformatf("R2 R3 R5 row%0d ins_char", i), ins_char, TBL[i][9:2]);
      chk($sformatf("R6 R7 R10 row%0d rts_n", i), rts_n, TBL[i][1]);
      chk($sformatf("R8 row%0d irq", i), rx_trig_irq, TBL[i][0]);
    end
    ins_ack = 1'b0;

    // R9: reset while paused in out-of-band mode
    sw_flow_en = 1'b0; hw_flow_en = 1'b1; rx_level = 7'd64;
    step();
    chk("R6 rts_n before reset", rts_n, 1);
    rst = 1'b1;
    step();
    step();
    chk("R9 rts_n in reset", rts_n, 0);
    chk("R9 irq in reset", rx_trig_irq, 0);
    chk("R9 ins_char in reset", ins_char, 0);
    rst = 1'b0;
    // paused state cleared: dropping below restart requests no resume char
    sw_flow_en = 1'b1; hw_flow_en = 1'b0; rx_level = 7'd20;
    step();
    chk("R9 no resume after reset", ins_req, 0);

    // R8: trigger field 0 fires on any nonzero level
    trig_cfg = 4'h0; rx_level = 7'd0;
    step();
    chk("R8 trig0 empty", rx_trig_irq, 0);
    rx_level = 7'd1;
    step();
    chk("R8 trig0 one entry", rx_trig_irq, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule